// File: doc/BRIEF.md
# Shared bus-strobe / calibration-clock pin generator

This block produces the level and the drive enable of one output pin that is shared by three functions. In an expanded (external bus) mode the pin normally carries an active-low data-bus strobe that opens the external data window while the bus E clock is high. When an external access is stretched by extra E cycles, the strobe is held off until the final quarter of the last cycle. Two alternatives can take over the pin. One is an inverted copy of the E clock, which an external latch can use to capture a multiplexed address. The other is a calibration clock taken from a programmable slow-clock divider with a 50 % duty cycle.

The E clock is not generated here. A 2-bit quarter-phase input describes it: values 0 and 1 mean E is low, and values 2 and 3 mean E is high. The phase advances by one per oscillator clock. A stretch input gives the number of extra E cycles per external access. A small configuration register selects the function. It holds a strobe-disable bit, an inverted-E enable bit and a calibration enable bit, and it is loaded together with the requested divider value through a single write strobe.

Top module: `busen_cal_pin`

## Requirements
- R1: With the strobe selected and a stretch of 0, the pin is low exactly in quarters 2 and 3 of each E cycle (E high) and high in quarters 0 and 1. The drive enable is 1.
- R2: With the strobe selected and a stretch S of 1 to 3, an access spans S+1 E cycles counted from reset. The pin is low only in quarter 3 of the cycle with index S and high in every other quarter.
- R3: After reset the strobe-disable bit is 0, the calibration enable is 1, the inverted-E enable is 0 and the divider value is 0. In expanded mode the pin therefore carries the strobe. In single-chip mode it carries the calibration clock at the oscillator frequency (high while the clock is high, low while it is low).
- R4: With the strobe-disable bit at 1 and the inverted-E enable at 1, the pin equals the inverse of E (1 in quarters 0–1, 0 in quarters 2–3) in either mode. The drive enable is 1.
- R5: Selection priority is strobe (expanded mode and strobe-disable 0), then inverted E, then the calibration clock (calibration enable 1). In particular, the strobe overrides an enabled calibration clock.
- R6: When no function is selected, the drive enable is 0 and the pin is 0.
- R7: A divider value N of 1 or more gives a calibration clock with a period of 2N oscillator cycles, high for N and low for N. A value of 0 passes the oscillator clock through.
- R8: A new divider value takes effect only at the next rising edge of the divided clock, so every period keeps equal high and low times (no runt pulse).
- R9: A configuration write presented with the write strobe takes effect in the cycle after the clock edge that captures it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| expanded_i | input | 1 | 1 = expanded bus mode, 0 = single-chip |
| eph_i | input | 2 | E-clock quarter phase (0–1 E low, 2–3 E high) |
| stretch_i | input | STR_W | Extra E cycles per external access |
| cfg_we_i | input | 1 | Configuration write strobe |
| strobe_off_i | input | 1 | Write data: 1 disables the bus strobe |
| inv_e_en_i | input | 1 | Write data: inverted-E enable |
| cal_en_i | input | 1 | Write data: calibration clock enable |
| div_i | input | DIV_W | Write data: divider value |
| pin_o | output | 1 | Pin level |
| pin_oe_o | output | 1 | Pin drive enable |

## Verification
The strobe is exercised with stretch values of 0, 1 and 3, each phase-aligned from reset. This separates the plain E-high window from the last-quarter-of-last-cycle window, and it exposes an off-by-one in the stretch cycle count. The selection logic is driven through every combination of interest: expanded and single-chip mode, the inverted-E enable both with and without the strobe-disable bit, and all functions off. These cases distinguish the priority order from a simple OR of the enables. The divider is measured as run lengths of the pin for small N and across a change of N from 3 to 5. Equal high and low runs in every period show that the change was deferred to a rising edge, and the N = 0 case is sampled in both clock phases to confirm the pass-through.

// File: rtl/busen_cal_pkg.sv
package busen_cal_pkg;

    typedef enum logic [1:0] {
        SEL_OFF    = 2'd0,
        SEL_STROBE = 2'd1,
        SEL_INVE   = 2'd2,
        SEL_CAL    = 2'd3
    } pin_sel_e;

    typedef struct packed {
        logic strobe_off;
        logic inv_e_en;
        logic cal_en;
    } pin_cfg_t;

    localparam pin_cfg_t CFG_RESET = '{strobe_off: 1'b0, inv_e_en: 1'b0, cal_en: 1'b1};

    localparam logic [1:0] PH_LAST = 2'd3;

endpackage

// File: rtl/ebus_strobe_win.sv
module ebus_strobe_win #(
    parameter int STR_W = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [1:0]       eph_i,
    input  logic [STR_W-1:0] stretch_i,
    output logic             win_o,
    output logic [STR_W-1:0] cyc_o
);
    import busen_cal_pkg::*;

    typedef struct packed {
        logic [STR_W-1:0] cyc;
    } st_t;

    st_t st_d, st_q;
    logic last_cyc;

    always_comb begin
        st_d     = st_q;
        last_cyc = (st_q.cyc >= stretch_i);
        if (eph_i == PH_LAST) begin
            st_d.cyc = last_cyc ? '0 : st_q.cyc + 1'b1;
        end
        if (stretch_i == '0) begin
            win_o = eph_i[1];
        end else begin
            win_o = (st_q.cyc == stretch_i) && (eph_i == PH_LAST);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cyc_o = st_q.cyc;

endmodule

// File: rtl/slow_clk_div.sv
module slow_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] req_i,
    output logic             cal_o,
    output logic             lvl_o,
    output logic [DIV_W-1:0] act_n_o
);
    localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [DIV_W-1:0] n;
        logic [DIV_W-1:0] cnt;
        logic             lvl;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.n == '0) begin
            st_d.n   = req_i;
            st_d.cnt = ONE;
            st_d.lvl = 1'b1;
        end else if (st_q.cnt == st_q.n) begin
            st_d.lvl = ~st_q.lvl;
            st_d.cnt = ONE;
            if (!st_q.lvl) begin
                st_d.n = req_i;
            end
        end else begin
            st_d.cnt = st_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{n: '0, cnt: ONE, lvl: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign cal_o   = (st_q.n == '0) ? clk_i : st_q.lvl;
    assign lvl_o   = st_q.lvl;
    assign act_n_o = st_q.n;

endmodule

// File: rtl/pin_func_sel.sv
module pin_func_sel (
    input  logic                    expanded_i,
    input  busen_cal_pkg::pin_cfg_t cfg_i,
    input  logic                    win_i,
    input  logic                    e_high_i,
    input  logic                    cal_i,
    output busen_cal_pkg::pin_sel_e sel_o,
    output logic                    pin_o,
    output logic                    oe_o
);
    import busen_cal_pkg::*;

    always_comb begin
        if (expanded_i && !cfg_i.strobe_off) begin
            sel_o = SEL_STROBE;
        end else if (cfg_i.strobe_off && cfg_i.inv_e_en) begin
            sel_o = SEL_INVE;
        end else if (cfg_i.cal_en) begin
            sel_o = SEL_CAL;
        end else begin
            sel_o = SEL_OFF;
        end

        unique case (sel_o)
            SEL_STROBE: pin_o = ~win_i;
            SEL_INVE:   pin_o = ~e_high_i;
            SEL_CAL:    pin_o = cal_i;
            default:    pin_o = 1'b0;
        endcase
        oe_o = (sel_o != SEL_OFF);
    end

endmodule

// File: rtl/busen_cal_pin.sv
module busen_cal_pin #(
    parameter int STR_W = 2,
    parameter int DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             expanded_i,
    input  logic [1:0]       eph_i,
    input  logic [STR_W-1:0] stretch_i,
    input  logic             cfg_we_i,
    input  logic             strobe_off_i,
    input  logic             inv_e_en_i,
    input  logic             cal_en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             pin_o,
    output logic             pin_oe_o
);
    import busen_cal_pkg::*;

    typedef struct packed {
        pin_cfg_t         cfg;
        logic [DIV_W-1:0] div_req;
    } st_t;

    st_t st_d, st_q;

    logic             win;
    logic [STR_W-1:0] cyc;
    logic             cal_clk;
    logic             div_lvl;
    logic [DIV_W-1:0] div_act;
    pin_sel_e         sel;

    always_comb begin
        st_d = st_q;
        if (cfg_we_i) begin
            st_d.cfg.strobe_off = strobe_off_i;
            st_d.cfg.inv_e_en   = inv_e_en_i;
            st_d.cfg.cal_en     = cal_en_i;
            st_d.div_req        = div_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{cfg: CFG_RESET, div_req: '0};
        end else begin
            st_q <= st_d;
        end
    end

    ebus_strobe_win #(.STR_W(STR_W)) u_win (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .eph_i     (eph_i),
        .stretch_i (stretch_i),
        .win_o     (win),
        .cyc_o     (cyc)
    );

    slow_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .req_i   (st_q.div_req),
        .cal_o   (cal_clk),
        .lvl_o   (div_lvl),
        .act_n_o (div_act)
    );

    pin_func_sel u_sel (
        .expanded_i (expanded_i),
        .cfg_i      (st_q.cfg),
        .win_i      (win),
        .e_high_i   (eph_i[1]),
        .cal_i      (cal_clk),
        .sel_o      (sel),
        .pin_o      (pin_o),
        .oe_o       (pin_oe_o)
    );

endmodule

// File: rtl/busen_cal_pin_chk.sv
module busen_cal_pin_chk #(
    parameter int STR_W = 2,
    parameter int DIV_W = 8
) (
    input logic                    clk_i,
    input logic                    rst_ni,
    input logic [1:0]              eph_i,
    input logic [STR_W-1:0]        stretch_i,
    input logic                    pin_o,
    input logic                    pin_oe_o,
    input busen_cal_pkg::pin_sel_e sel_i,
    input logic [STR_W-1:0]        cyc_i,
    input logic                    lvl_i,
    input logic [DIV_W-1:0]        act_n_i
);
    import busen_cal_pkg::*;

    AST_STROBE_IN_E_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i == SEL_STROBE && !pin_o) |-> eph_i[1]); // R1

    AST_STRETCH_EARLY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i == SEL_STROBE && stretch_i != '0 && cyc_i != stretch_i) |-> pin_o); // R2

    AST_INVE_OPPOSITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i == SEL_INVE) |-> (pin_o != eph_i[1] && pin_oe_o)); // R4

    AST_OFF_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i == SEL_OFF) |-> (!pin_oe_o && !pin_o)); // R6

    AST_DIV_SWAP_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act_n_i != $past(act_n_i)) |-> ($past(act_n_i) == '0 || (lvl_i && !$past(lvl_i)))); // R8

endmodule

bind busen_cal_pin busen_cal_pin_chk #(.STR_W(STR_W), .DIV_W(DIV_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .eph_i     (eph_i),
    .stretch_i (stretch_i),
    .pin_o     (pin_o),
    .pin_oe_o  (pin_oe_o),
    .sel_i     (sel),
    .cyc_i     (cyc),
    .lvl_i     (div_lvl),
    .act_n_i   (div_act)
);

// File: tb/tb_busen_cal_pin.sv
module tb_busen_cal_pin;
    localparam int STR_W = 2;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             expanded = 1'b0;
    logic [1:0]       eph = 2'd0;
    logic [STR_W-1:0] stretch = '0;
    logic             cfg_we = 1'b0;
    logic             s_off = 1'b0;
    logic             inv_en = 1'b0;
    logic             cal_en = 1'b1;
    logic [DIV_W-1:0] div = '0;
    logic             pin;
    logic             oe;

    int n_chk = 0;
    int n_bad = 0;
    int qidx = 0;
    int runs [64];
    int nr = 0;

    always #4 clk = ~clk;

    busen_cal_pin #(.STR_W(STR_W), .DIV_W(DIV_W)) dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .expanded_i   (expanded),
        .eph_i        (eph),
        .stretch_i    (stretch),
        .cfg_we_i     (cfg_we),
        .strobe_off_i (s_off),
        .inv_e_en_i   (inv_en),
        .cal_en_i     (cal_en),
        .div_i        (div),
        .pin_o        (pin),
        .pin_oe_o     (oe)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: quarter %0d got %b expected %b", req, qidx, act, exp);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // advance one oscillator cycle; ends at posedge+2 (clock high)
    task automatic step();
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        qidx++;
        eph = qidx[1:0];
        #1;
    endtask

    task automatic do_reset(input logic exp_mode, input logic [STR_W-1:0] s);
        rst_n = 1'b0;
        cfg_we = 1'b0;
        expanded = exp_mode;
        stretch = s;
        qidx = 0;
        eph = 2'd0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #1;
    endtask

    task automatic wr_cfg(input logic so, input logic ie, input logic ce, input int d);
        s_off = so;
        inv_en = ie;
        cal_en = ce;
        div = d[DIV_W-1:0];
        cfg_we = 1'b1;
        step();
    endtask

    function automatic logic strobe_pin(input int q, input int s);
        logic win;
        if (s == 0) win = (q % 4) >= 2;
        else        win = ((q / 4) % (s + 1)) == s && (q % 4) == 3;
        return !win;
    endfunction

    task automatic t_reset_state();
        do_reset(1'b1, '0);
        check("R3 expanded oe", oe, 1'b1);
        check("R3 expanded strobe idle", pin, 1'b1);
        step(); step();
        check("R3 expanded strobe active", pin, 1'b0);
        do_reset(1'b0, '0);
        check("R3 single-chip oe", oe, 1'b1);
        check("R3 cal pass-through clk high", pin, 1'b1);
        #4;
        check("R3 cal pass-through clk low", pin, 1'b0);
    endtask

    task automatic t_strobe(input int s);
        do_reset(1'b1, s[STR_W-1:0]);
        for (int i = 0; i < 8 * (s + 1); i++) begin
            if (s == 0) check("R1 strobe window", pin, strobe_pin(qidx, s));
            else        check("R2 stretched strobe", pin, strobe_pin(qidx, s));
            check("R1 strobe oe", oe, 1'b1);
            step();
        end
    endtask

    task automatic t_inv_e(input logic mode);
        do_reset(mode, '0);
        wr_cfg(1'b1, 1'b1, 1'b1, 0);
        for (int i = 0; i < 8; i++) begin
            check("R4 inverted E", pin, !eph[1]);
            check("R4 inverted E oe", oe, 1'b1);
            step();
        end
    endtask

    task automatic t_priority();
        do_reset(1'b1, '0);
        wr_cfg(1'b0, 1'b1, 1'b1, 0);
        for (int i = 0; i < 8; i++) begin
            check("R5 strobe over cal and inverted E", pin, strobe_pin(qidx, 0));
            step();
        end
        do_reset(1'b0, '0);
        wr_cfg(1'b0, 1'b1, 1'b1, 0);
        for (int i = 0; i < 4; i++) begin
            check("R5 single-chip cal clk high", pin, 1'b1);
            #4;
            check("R5 single-chip cal clk low", pin, 1'b0);
            step();
        end
    endtask

    task automatic t_off();
        do_reset(1'b1, '0);
        wr_cfg(1'b1, 1'b0, 1'b0, 0);
        for (int i = 0; i < 4; i++) begin
            check("R6 off oe", oe, 1'b0);
            check("R6 off pin", pin, 1'b0);
            step();
        end
        do_reset(1'b0, '0);
        wr_cfg(1'b0, 1'b1, 1'b0, 0);
        check("R6 single-chip off oe", oe, 1'b0);
        check("R6 single-chip off pin", pin, 1'b0);
    endtask

    task automatic collect(input int nsamp);
        logic prev, cur, started;
        int len;
        nr = 0;
        started = 1'b0;
        len = 0;
        prev = pin;
        for (int i = 0; i < nsamp; i++) begin
            step();
            cur = pin;
            if (!started) begin
                if (cur && !prev) begin
                    started = 1'b1;
                    len = 1;
                end
            end else if (cur == prev) begin
                len++;
            end else if (nr < 64) begin
                runs[nr] = len;
                nr++;
                len = 1;
            end
            prev = cur;
        end
    endtask

    task automatic t_divider(input int n);
        do_reset(1'b0, '0);
        wr_cfg(1'b0, 1'b0, 1'b1, n);
        collect(10 * n + 8);
        check_int("R7 run count", (nr >= 4) ? 1 : 0, 1);
        for (int i = 0; i < 4 && i < nr; i++) begin
            check_int("R7 divided half period", runs[i], n);
        end
    endtask

    task automatic t_div_change();
        int last_pair;
        do_reset(1'b0, '0);
        wr_cfg(1'b0, 1'b0, 1'b1, 3);
        repeat (13) step();
        wr_cfg(1'b0, 1'b0, 1'b1, 5);
        collect(60);
        last_pair = 0;
        for (int i = 0; i + 1 < nr; i += 2) begin
            check_int("R8 equal high and low", runs[i], runs[i + 1]);
            check_int("R8 legal half period", (runs[i] == 3 || runs[i] == 5) ? 1 : 0, 1);
            last_pair = runs[i];
        end
        check_int("R8 new value in effect", last_pair, 5);
    endtask

    task automatic t_cfg_timing();
        do_reset(1'b1, '0);
        s_off = 1'b1;
        inv_en = 1'b0;
        cal_en = 1'b0;
        cfg_we = 1'b1;
        #1;
        check("R9 before capture oe", oe, 1'b1);
        step();
        check("R9 after capture oe", oe, 1'b0);
    endtask

    initial begin
        t_reset_state();
        t_strobe(0);
        t_strobe(1);
        t_strobe(3);
        t_inv_e(1'b1);
        t_inv_e(1'b0);
        t_priority();
        t_off();
        t_divider(1);
        t_divider(2);
        t_divider(4);
        t_div_change();
        t_cfg_timing();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #800000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule